// File: doc/BRIEF.md
# Activation-Count Targeted Row Refresher

This block sits beside the command scheduler of one DRAM bank and watches every row-activate command that goes to that bank. It keeps a small fully associative table of recently active rows. Each entry holds a count of activations within the current counting window. When an activation pushes a row's count above a programmable limit, the block asks for extra refreshes of the physically adjacent rows. Optionally it also asks for the rows two positions away. The aggressor's count then starts again from zero.

Separately from the counters, a pseudo-random generator occasionally selects the row that was just activated and requests a refresh of one of its immediate neighbours. Requests are queued in a short FIFO and handed to the scheduler over a valid/ready pair. A fallback configuration turns all tracking off and instead signals that the regular refresh rate should be doubled. The window boundary is an input tick supplied by the controller's refresh timer; by default that timer is aligned with the 64 ms retention period.

Top module: `trr_refresher`

## Requirements
- R1: While `rst` is high and in the cycle after it, `trr_valid`, `trr_ovf` and `dbl_rate` are 0, the table is empty and the random generator holds the seed 16'hACE1. Queued requests are discarded.
- R2: An activation (`act_valid` high while `cfg_fallback` is low) increments its row's count. If the count after this activation is greater than `cfg_mac`, the victims row−1 and then row+1 are queued in that order. They are visible at the FIFO output from the next cycle.
- R3: In the cycle its victims are queued, the triggering row's count returns to 0. It needs another `cfg_mac`+1 activations to trigger again.
- R4: With `cfg_dist2` high, a trigger also queues row−2 and then row+2, after the two distance-one victims.
- R5: A victim address below 0 or above 2^ROW_W−1 is not generated. No wrap-around takes place.
- R6: `win_tick` empties the table. An activation in the same cycle as the tick counts as the first activation of the new window.
- R7: The table has 16 slots, and new rows fill the lowest free slot. When the table is full, a new row takes the slot with the lowest count, with the lowest slot index winning ties. The new row starts at count 1.
- R8: On each activation the generator state S is tested. If S & `cfg_rand_mask` is 0, a random request is queued after any targeted victims. The request names row+1 when S[15] is 1 and row−1 otherwise, and uses the other side if the chosen one is out of range. S then advances to (S>>1) ^ (S[0] ? 16'hB400 : 0). A mask of 16'hFFFF never fires.
- R9: Requests leave in the order they were queued, through a 4-entry FIFO. `trr_valid` shows a non-empty queue, and `trr_row` holds the oldest request stable until `trr_ready` accepts it.
- R10: Requests that do not fit are dropped. Free space counts a pop made in the same cycle, and requests are kept in the order of R2, R4, R8. A drop raises `trr_ovf` for exactly the next cycle.
- R11: While `cfg_fallback` is high, no activation is counted and no request is queued. The table is emptied, the generator does not advance, and `dbl_rate` follows `cfg_fallback` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Row-activate command seen this cycle |
| act_row | input | 14 | Row address of the activation |
| win_tick | input | 1 | Counting-window boundary |
| cfg_mac | input | 16 | Activation limit per window |
| cfg_dist2 | input | 1 | Also refresh rows at distance two |
| cfg_rand_mask | input | 16 | Probability mask for random neighbour refresh |
| cfg_fallback | input | 1 | Disable tracking, request doubled refresh rate |
| trr_ready | input | 1 | Scheduler accepts the head request |
| trr_valid | output | 1 | A targeted-refresh request is pending |
| trr_row | output | 14 | Row to refresh |
| trr_ovf | output | 1 | One-cycle pulse after requests were dropped |
| dbl_rate | output | 1 | Doubled regular refresh rate requested |

## Verification
The bench targets the trigger edge: a design that compares with ≥ instead of > would fire one activation early. It also checks that an aggressor retriggers only after a full new batch, which catches a count that is not cleared. Rows 0, 1 and the top two addresses are hammered with distance two enabled, so any victim that wraps round would show up as a far-away address. The bench also forces eviction from a full table with tied counts, which exposes a wrong tie rule as a different row being forgotten. A tick that coincides with an activation is tested too, which catches a design that loses that activation. Finally it overfills the FIFO while the scheduler is stalled and while it pops in the same cycle. This separates a design that ignores the freed slot, or reorders targeted and random requests, from a correct one.

// File: rtl/trr_pkg.sv
package trr_pkg;

    localparam int ROW_W      = 14;
    localparam int CNT_W      = 16;
    localparam int RND_W      = 16;
    localparam int NSLOT      = 5;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [RND_W-1:0] rnd_t;

    typedef struct packed {
        logic vld;
        row_t row;
        cnt_t cnt;
    } hot_ent_t;

    typedef struct packed {
        logic vld;
        row_t row;
    } vreq_t;

    // Neighbour at signed distance d; invalid when it leaves the bank.
    function automatic vreq_t near_row(row_t r, int d);
        vreq_t res;
        int    t;
        t       = int'(r) + d;
        res.vld = (t >= 0) && (t < (1 << ROW_W));
        res.row = row_t'(t);
        return res;
    endfunction

    function automatic rnd_t rnd_next(rnd_t s);
        return (s >> 1) ^ (s[0] ? RND_TAPS : '0);
    endfunction

endpackage

// File: rtl/trr_hot_table.sv
module trr_hot_table
    import trr_pkg::*;
#(
    parameter int TBL_N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic upd,
    input  row_t row,
    input  cnt_t mac,
    output logic trig
);
    localparam int IW = (TBL_N > 1) ? $clog2(TBL_N) : 1;

    hot_ent_t        tbl_q [TBL_N];
    logic            hit, free_ok, min_ok;
    logic [IW-1:0]   hit_idx, free_idx, min_idx, tgt;
    cnt_t            min_cnt, base;
    logic [CNT_W:0]  cnt_inc;
    hot_ent_t        new_ent;
    logic [TBL_N-1:0] occupied;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        min_ok   = 1'b0;
        min_idx  = '0;
        min_cnt  = '0;
        for (int i = 0; i < TBL_N; i++) begin
            if (tbl_q[i].vld && !clear) begin
                if (!hit && tbl_q[i].row == row) begin
                    hit     = 1'b1;
                    hit_idx = IW'(i);
                end
                if (!min_ok || tbl_q[i].cnt < min_cnt) begin
                    min_ok  = 1'b1;
                    min_cnt = tbl_q[i].cnt;
                    min_idx = IW'(i);
                end
            end else if (!free_ok) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end
        tgt     = hit ? hit_idx : (free_ok ? free_idx : min_idx);
        base    = hit ? tbl_q[hit_idx].cnt : '0;
        cnt_inc = {1'b0, base} + 1'b1;
        trig    = upd && (cnt_inc > {1'b0, mac});
        new_ent.vld = 1'b1;
        new_ent.row = row;
        new_ent.cnt = trig ? '0 : cnt_inc[CNT_W-1:0];
    end

    always_comb begin
        for (int i = 0; i < TBL_N; i++) occupied[i] = tbl_q[i].vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_N; i++) tbl_q[i] <= '0;
        end else begin
            if (clear) begin
                for (int i = 0; i < TBL_N; i++) tbl_q[i].vld <= 1'b0;
            end
            if (upd) tbl_q[tgt] <= new_ent;
        end
    end

    // R3: a triggering row is left with a zero count
    p_trig_zero_r3: assert property (@(posedge clk) disable iff (rst)
        trig |=> (tbl_q[$past(tgt)].cnt == '0));

    // R6: a boundary without activation leaves no row tracked
    p_clear_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (clear && !upd) |=> (occupied == '0));

endmodule

// File: rtl/trr_rand_pick.sv
module trr_rand_pick
    import trr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  row_t  row,
    input  rnd_t  mask,
    output vreq_t pick
);
    rnd_t  st_q;
    vreq_t up_n, dn_n;

    assign up_n = near_row(row, 1);
    assign dn_n = near_row(row, -1);

    always_comb begin
        pick.vld = step && ((st_q & mask) == '0);
        if (st_q[RND_W-1]) pick.row = up_n.vld ? up_n.row : dn_n.row;
        else               pick.row = dn_n.vld ? dn_n.row : up_n.row;
    end

    always_ff @(posedge clk) begin
        if (rst)       st_q <= RND_SEED;
        else if (step) st_q <= rnd_next(st_q);
    end

    // R8: the generator never locks up in the all-zero state
    p_rnd_live_r8: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);

    // R11: without a counted activation the generator stands still
    p_rnd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q));

endmodule

// File: rtl/trr_req_fifo.sv
module trr_req_fifo
    import trr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NIN   = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  vreq_t push [NIN],
    input  logic  ready,
    output logic  valid,
    output row_t  head,
    output logic  ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    row_t          mem_q [DEPTH];
    row_t          mem_n [DEPTH];
    logic [PW-1:0] rp_q, wp_q, rp_n, wp_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          ovf_q, drop, pop;
    int            space, nw;

    assign valid = (cnt_q != '0);
    assign head  = mem_q[rp_q];
    assign ovf   = ovf_q;
    assign pop   = valid && ready;

    always_comb begin
        mem_n = mem_q;
        space = DEPTH - int'(cnt_q) + (pop ? 1 : 0);
        nw    = 0;
        drop  = 1'b0;
        for (int k = 0; k < NIN; k++) begin
            if (push[k].vld) begin
                if (nw < space) begin
                    mem_n[PW'((int'(wp_q) + nw) % DEPTH)] = push[k].row;
                    nw = nw + 1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
        wp_n  = PW'((int'(wp_q) + nw) % DEPTH);
        rp_n  = pop ? PW'((int'(rp_q) + 1) % DEPTH) : rp_q;
        cnt_n = CW'(int'(cnt_q) - (pop ? 1 : 0) + nw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            rp_q  <= rp_n;
            wp_q  <= wp_n;
            cnt_q <= cnt_n;
            ovf_q <= drop;
            mem_q <= mem_n;
        end
    end

    // R9: occupancy stays within the storage
    p_cap_r9: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);

    // R9: a stalled head request is neither lost nor altered
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(head)));

    // R10: a drop only happens once the queue has been filled
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (int'(cnt_q) == DEPTH));

endmodule

// File: rtl/trr_refresher.sv
module trr_refresher
    import trr_pkg::*;
#(
    parameter int TBL_N  = 16,
    parameter int FIFO_D = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_valid,
    input  logic [ROW_W-1:0] act_row,
    input  logic             win_tick,
    input  logic [CNT_W-1:0] cfg_mac,
    input  logic             cfg_dist2,
    input  logic [RND_W-1:0] cfg_rand_mask,
    input  logic             cfg_fallback,
    input  logic             trr_ready,
    output logic             trr_valid,
    output logic [ROW_W-1:0] trr_row,
    output logic             trr_ovf,
    output logic             dbl_rate
);
    localparam int NVICT = NSLOT - 1;

    logic  upd, clear, trig, dbl_q;
    vreq_t slots [NSLOT];
    vreq_t rnd_req;

    assign upd   = act_valid && !cfg_fallback;
    assign clear = win_tick || cfg_fallback;

    trr_hot_table #(.TBL_N(TBL_N)) u_table (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .upd   (upd),
        .row   (act_row),
        .mac   (cfg_mac),
        .trig  (trig)
    );

    trr_rand_pick u_rand (
        .clk  (clk),
        .rst  (rst),
        .step (upd),
        .row  (act_row),
        .mask (cfg_rand_mask),
        .pick (rnd_req)
    );

    // Slots in queue order: -1, +1, -2, +2, then the random neighbour.
    for (genvar g = 0; g < NVICT; g++) begin : g_vict
        localparam int DIST = ((g / 2) + 1) * (((g % 2) == 1) ? 1 : -1);
        vreq_t nb;
        assign nb             = near_row(act_row, DIST);
        assign slots[g].vld   = nb.vld && trig && ((g < 2) || cfg_dist2);
        assign slots[g].row   = nb.row;
    end
    assign slots[NVICT] = rnd_req;

    trr_req_fifo #(.DEPTH(FIFO_D), .NIN(NSLOT)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (slots),
        .ready (trr_ready),
        .valid (trr_valid),
        .head  (trr_row),
        .ovf   (trr_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) dbl_q <= 1'b0;
        else     dbl_q <= cfg_fallback;
    end
    assign dbl_rate = dbl_q;

    // R11: in fallback an empty queue stays empty
    p_fb_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_fallback && !trr_valid) |=> !trr_valid);

    // R2: a trigger always yields at least one queued request
    p_trig_queues_r2: assert property (@(posedge clk) disable iff (rst)
        trig |=> (trr_valid || trr_ovf));

endmodule

// File: tb/tb_trr_refresher.sv
module tb_trr_refresher;
    import trr_pkg::*;

    localparam int MAXR = (1 << ROW_W) - 1;
    localparam int QD   = 4;
    localparam int TN   = 16;

    logic             clk = 1'b0;
    logic             rst, act_valid, win_tick, cfg_dist2, cfg_fallback, trr_ready;
    logic [ROW_W-1:0] act_row;
    logic [CNT_W-1:0] cfg_mac;
    logic [RND_W-1:0] cfg_rand_mask;
    logic             trr_valid, trr_ovf, dbl_rate;
    logic [ROW_W-1:0] trr_row;

    always #5 clk = ~clk;

    trr_refresher dut (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_row(act_row),
        .win_tick(win_tick), .cfg_mac(cfg_mac), .cfg_dist2(cfg_dist2),
        .cfg_rand_mask(cfg_rand_mask), .cfg_fallback(cfg_fallback),
        .trr_ready(trr_ready), .trr_valid(trr_valid), .trr_row(trr_row),
        .trr_ovf(trr_ovf), .dbl_rate(dbl_rate)
    );

    // next-cycle stimulus
    int nx_rst = 1, nx_act = 0, nx_row = 0, nx_tick = 0, nx_mac = 3;
    int nx_dist2 = 0, nx_mask = 'hFFFF, nx_fb = 0, nx_ready = 1;

    int    n_chk = 0, n_bad = 0, cycles = 0;
    string tag = "R1";
    bit    armed = 1'b0;

    // reference model state
    int m_vld [TN];
    int m_row [TN];
    int m_cnt [TN];
    int q [$];
    int m_ovf = 0, m_dbl = 0, m_rnd = 'hACE1;

    task automatic chk(bit ok, string req, string what, int a, int e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, a, e);
        end
    endtask

    task automatic compare();
        if (!armed) return;
        chk(trr_valid === (q.size() > 0), tag, "trr_valid", int'(trr_valid), int'(q.size() > 0));
        if (q.size() > 0 && trr_valid === 1'b1)
            chk(int'(trr_row) == q[0], tag, "trr_row", int'(trr_row), q[0]);
        chk(trr_ovf === m_ovf[0], tag, "trr_ovf", int'(trr_ovf), m_ovf);
        chk(dbl_rate === m_dbl[0], tag, "dbl_rate", int'(dbl_rate), m_dbl);
    endtask

    function automatic bit in_bank(int r);
        return (r >= 0) && (r <= MAXR);
    endfunction

    task automatic model_step();
        int  pushes [$];
        bit  pop;
        int  slot, c, best;
        if (nx_rst != 0) begin
            for (int i = 0; i < TN; i++) begin m_vld[i] = 0; m_cnt[i] = 0; m_row[i] = 0; end
            q.delete();
            m_ovf = 0; m_dbl = 0; m_rnd = 'hACE1;
            return;
        end
        pop = (q.size() > 0) && (nx_ready != 0);
        if (nx_fb != 0 || nx_tick != 0)
            for (int i = 0; i < TN; i++) m_vld[i] = 0;
        if (nx_act != 0 && nx_fb == 0) begin
            slot = -1;
            for (int i = 0; i < TN; i++)
                if (slot < 0 && m_vld[i] != 0 && m_row[i] == nx_row) slot = i;
            if (slot >= 0) c = m_cnt[slot] + 1;
            else begin
                c = 1;
                for (int i = 0; i < TN; i++) if (slot < 0 && m_vld[i] == 0) slot = i;
                if (slot < 0) begin
                    best = 0;
                    for (int i = 1; i < TN; i++) if (m_cnt[i] < m_cnt[best]) best = i;
                    slot = best;
                end
            end
            m_vld[slot] = 1; m_row[slot] = nx_row;
            if (c > nx_mac) begin
                m_cnt[slot] = 0;
                if (in_bank(nx_row - 1)) pushes.push_back(nx_row - 1);
                if (in_bank(nx_row + 1)) pushes.push_back(nx_row + 1);
                if (nx_dist2 != 0) begin
                    if (in_bank(nx_row - 2)) pushes.push_back(nx_row - 2);
                    if (in_bank(nx_row + 2)) pushes.push_back(nx_row + 2);
                end
            end else begin
                m_cnt[slot] = c;
            end
            if ((m_rnd & nx_mask) == 0) begin
                int pref, alt;
                pref = ((m_rnd >> 15) & 1) != 0 ? nx_row + 1 : nx_row - 1;
                alt  = ((m_rnd >> 15) & 1) != 0 ? nx_row - 1 : nx_row + 1;
                pushes.push_back(in_bank(pref) ? pref : alt);
            end
            m_rnd = (m_rnd >> 1) ^ (((m_rnd & 1) != 0) ? 'hB400 : 0);
        end
        if (pop) void'(q.pop_front());
        m_ovf = 0;
        foreach (pushes[k]) begin
            if (q.size() < QD) q.push_back(pushes[k]);
            else m_ovf = 1;
        end
        m_dbl = (nx_fb != 0) ? 1 : 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
        rst           = nx_rst[0];
        act_valid     = nx_act[0];
        act_row       = ROW_W'(nx_row);
        win_tick      = nx_tick[0];
        cfg_mac       = CNT_W'(nx_mac);
        cfg_dist2     = nx_dist2[0];
        cfg_rand_mask = RND_W'(nx_mask);
        cfg_fallback  = nx_fb[0];
        trr_ready     = nx_ready[0];
        model_step();
        armed = 1'b1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic hit(int row);
        nx_act = 1; nx_row = row;
        cyc();
        nx_act = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; act_valid = 1'b0; act_row = '0; win_tick = 1'b0; cfg_mac = '0;
        cfg_dist2 = 1'b0; cfg_rand_mask = '1; cfg_fallback = 1'b0; trr_ready = 1'b1;

        tag = "R1";
        run(3);
        nx_rst = 0;
        run(2);
        chk(trr_valid === 1'b0, "R1", "trr_valid after reset", int'(trr_valid), 0);

        tag = "R2";           // limit 3: fourth activation triggers
        for (int i = 0; i < 4; i++) begin hit(100); run(1); end
        run(4);

        tag = "R3";           // count restarts after trigger
        for (int i = 0; i < 3; i++) hit(100);
        run(3);
        hit(100);
        run(4);

        tag = "R4";
        nx_dist2 = 1;
        for (int i = 0; i < 4; i++) hit(200);
        run(6);

        tag = "R5";           // every activation triggers, edges clipped
        nx_mac = 0;
        hit(0);        run(5);
        hit(1);        run(5);
        hit(MAXR);     run(5);
        hit(MAXR - 1); run(5);
        nx_dist2 = 0; nx_mac = 3;

        tag = "R6";
        for (int i = 0; i < 3; i++) hit(300);
        nx_tick = 1; cyc(); nx_tick = 0;
        for (int i = 0; i < 4; i++) hit(300);
        run(3);
        for (int i = 0; i < 3; i++) hit(301);
        nx_tick = 1; hit(301); nx_tick = 0;
        for (int i = 0; i < 3; i++) hit(301);
        run(4);

        tag = "R7";           // full table, eviction of lowest count
        nx_mac = 2;
        nx_tick = 1; cyc(); nx_tick = 0;
        for (int i = 0; i < 16; i++) hit(1000 + i);
        hit(1000);
        hit(2000);
        hit(1001);
        hit(2000); hit(2000);
        run(3);
        hit(1000); hit(1001); hit(1001);
        run(4);

        tag = "R8";           // random neighbour refresh
        nx_mac = 100; nx_mask = 0;
        for (int i = 0; i < 12; i++) begin hit(500 + i); run(1); end
        hit(0); run(2); hit(MAXR); run(2);
        nx_mask = 3;
        for (int i = 0; i < 40; i++) begin hit(520 + (i % 5)); run(1); end
        nx_mask = 'hFFFF;
        for (int i = 0; i < 10; i++) hit(530 + i);
        run(2);

        tag = "R9";           // stalled consumer, ordering kept
        nx_mac = 0; nx_ready = 0;
        hit(600); run(3);
        nx_ready = 1; run(1); nx_ready = 0; run(2);
        nx_ready = 1; run(4);

        tag = "R10";          // overflow while stalled, then pop with push
        nx_dist2 = 1; nx_ready = 0;
        hit(700); hit(800); hit(900); run(2);
        nx_ready = 1; hit(950); run(8);
        nx_ready = 0; hit(960); nx_ready = 1; hit(970); run(8);

        tag = "R1";           // reset discards queued requests
        nx_ready = 0; hit(980); run(1);
        nx_rst = 1; run(2); nx_rst = 0; nx_ready = 1; run(2);

        tag = "R11";
        nx_mac = 2; nx_dist2 = 0; nx_mask = 0; nx_fb = 1;
        for (int i = 0; i < 6; i++) hit(1100);
        run(2);
        nx_fb = 0; nx_mask = 'hFFFF;
        for (int i = 0; i < 3; i++) hit(1100);
        run(4);

        tag = "R2";           // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int pickv;
            if (i % 200 == 0) begin
                nx_mac   = int'($urandom % 5);
                nx_dist2 = int'($urandom % 2);
                pickv    = int'($urandom % 5);
                nx_mask  = (pickv == 0) ? 0 : (pickv == 1) ? 1 : (pickv == 2) ? 3 :
                           (pickv == 3) ? 7 : 'hFFFF;
            end
            if ($urandom % 150 == 0) nx_fb = (nx_fb != 0) ? 0 : 1;
            nx_act = ($urandom % 3 != 0) ? 1 : 0;
            pickv  = int'($urandom % 10);
            nx_row = (pickv == 0) ? 0 : (pickv == 1) ? MAXR : 40 + int'($urandom % 24);
            nx_tick  = ($urandom % 60 == 0) ? 1 : 0;
            nx_ready = ($urandom % 4 != 0) ? 1 : 0;
            cyc();
        end
        nx_act = 0; nx_fb = 0; nx_ready = 1;
        run(8);

        summary();
        $finish;
    end

endmodule